// File: doc/BRIEF.md
# Dynamically Sized Asynchronous Bus Master

This block is the master end of an asynchronous external bus with a 24-bit address and a 16-bit data path. Internal logic hands it one transfer at a time: a read or a write of a byte, a word or a long word. The block turns that transfer into one or more external bus cycles. Each cycle drives the address, two size lines, a read/write line, an address strobe and a data strobe. The cycle ends when the slave answers on two active-low acknowledge lines. That answer also tells the master whether the slave's port is 8 or 16 bits wide. The port width is never configured ahead of time. It is learned again on every cycle, and the master issues further cycles with an advanced address and a reduced size until the whole operand has moved. On reads the returned bytes are packed into one right-aligned result.

The block runs on a clock at twice the bus rate, so each clock edge stands for one half bus clock. The data path is bidirectional at the pad. Here it is split into an output bus, an output-enable and an input bus. Every bus cycle walks the same chain of states. ADDR drives the address, size and direction with both strobes high. ASRT asserts the address strobe. DRV puts write data on the bus. WAIT holds until an acknowledge arrives. LATCH is the last half clock, in which read data is taken. END releases both strobes and advances the address. From END the machine goes back to ADDR if bytes remain, or to IDLE when the operand is complete. The transitions are IDLE→ADDR on a request, then ADDR→ASRT→DRV→WAIT, WAIT→WAIT while no acknowledge is present, WAIT→LATCH→END, END→ADDR and END→IDLE. A new request is accepted only in IDLE.

Top module: `dyn_bus_master`

## Requirements
- R1: After reset, and whenever the block is idle, `as_n` and `ds_n` are high, `bus_doe` is low and `req_ready` is high. A reset during a bus cycle returns the block to this state.
- R2: The address strobe `as_n` falls one clock (one half bus clock) after `bus_addr`, `bus_siz` and `bus_rw` are set up. Those three outputs stay stable for as long as `as_n` is low.
- R3: On a read (`bus_rw`=1), `ds_n` falls in the same clock as `as_n`, and `bus_doe` stays low.
- R4: On a write (`bus_rw`=0), `bus_doe` rises one clock after `as_n` falls, and `ds_n` falls two clocks after `as_n` falls. On both reads and writes, `as_n` and `ds_n` rise together.
- R5: `dsack_n` is active low, with bit 1 and bit 0 as the two acknowledge lines. The value 01 or 00 ends the cycle and reports a 16-bit port. The value 10 ends the cycle and reports an 8-bit port. The value 11 ends nothing.
- R6: `bus_siz` gives the bytes still to move: 01 means one, 10 means two, 11 means three and 00 means four. After each cycle `bus_addr` rises by the number of bytes moved, and the size drops by the same number.
- R7: On a 16-bit port, a cycle moves two bytes when at least two remain and the address is even; otherwise it moves one byte. A long word therefore takes 2 cycles, and a word or a byte takes 1.
- R8: On an 8-bit port, each cycle moves one byte on lanes [15:8]. A long word takes 4 cycles and a word takes 2.
- R9: Writes drive all 16 data lines while `ds_n` is low. A cycle that moves two bytes puts the more significant byte on [15:8]. A cycle that moves the last single byte copies it onto both lanes.
- R10: `req_size` uses 00 for a byte, 01 for a word and 10 for a long word. Read data is returned on `rd_data` right-aligned, with the byte at the lowest address in the most significant position and unused upper bits zero. On a 16-bit port a byte at an even address comes from [15:8] and a byte at an odd address comes from [7:0].
- R11: `xfer_done` pulses for one clock as the block re-enters IDLE after the last cycle. At that point `req_ready` is high and `rd_data` holds the result.
- R12: While `dsack_n` is 11 in WAIT, both strobes stay asserted. Each half clock of waiting lengthens the strobe-low time by one clock; with no wait states the strobes stay low for 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the bus rate; one edge per half bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, sampled only while idle |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_size | input | 2 | Operand size: 00 byte, 01 word, 10 long word |
| req_addr | input | 24 | Address of the operand's most significant byte |
| req_wdata | input | 32 | Write operand, right-aligned |
| req_ready | output | 1 | High while idle and able to take a request |
| xfer_done | output | 1 | One-clock pulse when the transfer completes |
| rd_data | output | 32 | Reassembled read operand, right-aligned |
| bus_addr | output | 24 | External address |
| bus_siz | output | 2 | Bytes remaining, encoded as in R6 |
| bus_rw | output | 1 | 1 for a read cycle, 0 for a write cycle |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| bus_dout | output | 16 | Write data toward the pad |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Read data from the pad |
| dsack_n | input | 2 | Acknowledge and port-width lines, active low |

## Verification
The hardest situation to reach from the ports is a single operand that is split into several cycles with a different lane choice in each. One example is a long word through an 8-bit port with wait states, where the size must step 00, 11, 10, 01 and each byte must appear on the upper lane. The bench reaches it with a slave model that answers every strobe with a chosen acknowledge code after a chosen number of wait half-clocks. The model also returns read bytes computed from the address it sees. A table of vectors then pairs every operand size with every acknowledge code and with odd and even addresses. Directed tests add a long wait and a reset in the middle of a cycle.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASRT,
        ST_DRV,
        ST_WAIT,
        ST_LATCH,
        ST_END
    } bus_state_t;

    localparam logic [1:0] OP_BYTE = 2'b00;
    localparam logic [1:0] OP_WORD = 2'b01;
    localparam logic [1:0] OP_LONG = 2'b10;

    // number of bytes an operand of the given size carries
    function automatic logic [2:0] op_bytes(input logic [1:0] sz);
        unique case (sz)
            OP_BYTE: op_bytes = 3'd1;
            OP_WORD: op_bytes = 3'd2;
            default: op_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbm_ack_decode.sv
module dbm_ack_decode (
    input  logic [1:0] dsack_n,
    output logic       ack,
    output logic       port8
);
    // bit 1 alone or both low: 16-bit port; bit 0 alone low: 8-bit port
    always_comb begin
        ack   = (dsack_n != 2'b11);
        port8 = (dsack_n == 2'b10);
    end
endmodule

// File: rtl/dbm_step_calc.sv
module dbm_step_calc (
    input  logic [2:0] rem,
    input  logic       addr_lsb,
    input  logic       port8,
    output logic [1:0] step
);
    // one byte per cycle on a narrow port, on an odd address or for a lone byte
    always_comb begin
        if (port8 || addr_lsb || (rem == 3'd1))
            step = 2'd1;
        else
            step = 2'd2;
    end
endmodule

// File: rtl/dbm_lane_mux.sv
module dbm_lane_mux #(
    parameter int LANE_W = 8
) (
    input  logic [4*LANE_W-1:0] wbuf,
    input  logic [2:0]          rem,
    input  logic [2*LANE_W-1:0] din,
    input  logic                port8,
    input  logic                addr_lsb,
    output logic [2*LANE_W-1:0] wlanes,
    output logic [LANE_W-1:0]   rd_byte
);
    localparam int OPER_W = 4 * LANE_W;
    localparam int BUS_W  = 2 * LANE_W;

    logic [LANE_W-1:0] head;

    always_comb begin
        head = wbuf[OPER_W-1 -: LANE_W];
        if (rem == 3'd1)
            wlanes = {head, head};
        else
            wlanes = wbuf[OPER_W-1 -: BUS_W];
        if (port8 || !addr_lsb)
            rd_byte = din[BUS_W-1 -: LANE_W];
        else
            rd_byte = din[LANE_W-1:0];
    end
endmodule

// File: rtl/dyn_bus_master.sv
module dyn_bus_master #(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [4*LANE_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                xfer_done,
    output logic [4*LANE_W-1:0] rd_data,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [1:0]          bus_siz,
    output logic                bus_rw,
    output logic                as_n,
    output logic                ds_n,
    output logic [2*LANE_W-1:0] bus_dout,
    output logic                bus_doe,
    input  logic [2*LANE_W-1:0] bus_din,
    input  logic [1:0]          dsack_n
);
    import dbm_pkg::*;

    localparam int OPER_W = 4 * LANE_W;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int OPER_B = OPER_W / LANE_W;

    bus_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        rem_q;
    logic              write_q;
    logic              port8_q;
    logic              done_q;
    logic [OPER_W-1:0] wbuf_q;
    logic [OPER_W-1:0] rbuf_q;

    logic              ack_w;
    logic              port8_w;
    logic [1:0]        step_w;
    logic [BUS_W-1:0]  wlanes_w;
    logic [LANE_W-1:0] rd_byte_w;
    logic [2:0]        req_bytes;

    assign req_bytes = op_bytes(req_size);

    dbm_ack_decode u_ack (
        .dsack_n (dsack_n),
        .ack     (ack_w),
        .port8   (port8_w)
    );

    dbm_step_calc u_step (
        .rem      (rem_q),
        .addr_lsb (addr_q[0]),
        .port8    (port8_q),
        .step     (step_w)
    );

    dbm_lane_mux #(.LANE_W(LANE_W)) u_lane (
        .wbuf     (wbuf_q),
        .rem      (rem_q),
        .din      (bus_din),
        .port8    (port8_q),
        .addr_lsb (addr_q[0]),
        .wlanes   (wlanes_w),
        .rd_byte  (rd_byte_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_ASRT;
            ST_ASRT:  state_d = ST_DRV;
            ST_DRV:   state_d = ST_WAIT;
            ST_WAIT:  if (ack_w) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_END;
            ST_END:   state_d = (rem_q == 3'(step_w)) ? ST_IDLE : ST_ADDR;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand datapath
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            write_q <= 1'b0;
            port8_q <= 1'b0;
            done_q  <= 1'b0;
            wbuf_q  <= '0;
            rbuf_q  <= '0;
        end else begin
            done_q <= (state_q == ST_END) && (rem_q == 3'(step_w));
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        rem_q   <= req_bytes;
                        write_q <= req_write;
                        wbuf_q  <= req_wdata << (LANE_W * (OPER_B - int'(req_bytes)));
                        rbuf_q  <= '0;
                    end
                end
                ST_WAIT: begin
                    if (ack_w) port8_q <= port8_w;
                end
                ST_LATCH: begin
                    if (!write_q) begin
                        if (step_w == 2'd2)
                            rbuf_q <= {rbuf_q[OPER_W-BUS_W-1:0], bus_din};
                        else
                            rbuf_q <= {rbuf_q[OPER_W-LANE_W-1:0], rd_byte_w};
                    end
                end
                ST_END: begin
                    addr_q <= addr_q + ADDR_W'(step_w);
                    rem_q  <= rem_q - 3'(step_w);
                    wbuf_q <= wbuf_q << (LANE_W * int'(step_w));
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        xfer_done = done_q;
        rd_data   = rbuf_q;
        bus_addr  = addr_q;
        bus_siz   = rem_q[1:0];
        bus_rw    = !write_q || (state_q == ST_IDLE);
        bus_dout  = wlanes_w;
        as_n      = 1'b1;
        ds_n      = 1'b1;
        bus_doe   = 1'b0;
        unique case (state_q)
            ST_ASRT: begin
                as_n = 1'b0;
                ds_n = write_q;
            end
            ST_DRV: begin
                as_n    = 1'b0;
                ds_n    = write_q;
                bus_doe = write_q;
            end
            ST_WAIT, ST_LATCH: begin
                as_n    = 1'b0;
                ds_n    = 1'b0;
                bus_doe = write_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk2x,
    input logic              rst_n,
    input logic              req_ready,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_siz,
    input logic              bus_rw,
    input logic              as_n,
    input logic              ds_n,
    input logic              bus_doe,
    input logic [1:0]        dsack_n
);

    assert_idle_quiet_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
        req_ready |-> (as_n && ds_n && !bus_doe));

    assert_addr_stable_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!as_n && !$past(as_n)) |-> ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_rw)));

    assert_read_ds_with_as_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
        (bus_rw && $fell(as_n)) |-> !ds_n);

    assert_read_no_drive_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
        bus_rw |-> !bus_doe);

    assert_write_ds_late_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!bus_rw && $fell(as_n)) |=> ds_n);

    assert_ds_inside_as_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        !ds_n |-> !as_n);

    assert_strobes_rise_together_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(as_n) |-> ds_n);

    assert_write_all_lanes_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!bus_rw && !ds_n) |-> bus_doe);

    assert_done_in_idle_R11: assert property (@(posedge clk2x) disable iff (!rst_n)
        xfer_done |-> req_ready);

    assert_wait_holds_R12: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!as_n && !ds_n && dsack_n == 2'b11) |=> (!as_n && !ds_n));

endmodule

bind dyn_bus_master dbm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .xfer_done (xfer_done),
    .bus_addr  (bus_addr),
    .bus_siz   (bus_siz),
    .bus_rw    (bus_rw),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .bus_doe   (bus_doe),
    .dsack_n   (dsack_n)
);

// File: tb/sim_dyn_bus_master.sv
`timescale 1ns/1ps
module sim_dyn_bus_master;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [23:0] addr;
        logic [31:0] wd;
        logic [1:0]  ack;
        logic [7:0]  waits;
        logic [2:0]  ncyc;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b10, 24'h001000, 32'h00000000, 2'b01, 8'd0,  3'd2},
        '{1'b1, 2'b10, 24'h002004, 32'hA1B2C3D4, 2'b00, 8'd1,  3'd2},
        '{1'b0, 2'b10, 24'h003000, 32'h00000000, 2'b10, 8'd0,  3'd4},
        '{1'b1, 2'b10, 24'h004008, 32'h11223344, 2'b10, 8'd2,  3'd4},
        '{1'b0, 2'b01, 24'h00500A, 32'h00000000, 2'b01, 8'd0,  3'd1},
        '{1'b1, 2'b01, 24'h006002, 32'h0000BEEF, 2'b10, 8'd0,  3'd2},
        '{1'b0, 2'b00, 24'h007003, 32'h00000000, 2'b01, 8'd0,  3'd1},
        '{1'b1, 2'b00, 24'h008001, 32'h0000005A, 2'b01, 8'd0,  3'd1},
        '{1'b0, 2'b00, 24'h009005, 32'h00000000, 2'b10, 8'd1,  3'd1},
        '{1'b1, 2'b00, 24'h00A000, 32'h000000C3, 2'b00, 8'd3,  3'd1},
        '{1'b0, 2'b01, 24'hFFFFFE, 32'h00000000, 2'b10, 8'd0,  3'd2},
        '{1'b0, 2'b10, 24'h00C000, 32'h00000000, 2'b01, 8'd20, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, xfer_done;
    logic [31:0] rd_data;
    logic [23:0] bus_addr;
    logic [1:0]  bus_siz;
    logic        bus_rw, as_n, ds_n, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic [1:0]  dsack_n = 2'b11;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dyn_bus_master u0 (
        .clk2x     (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .xfer_done (xfer_done),
        .rd_data   (rd_data),
        .bus_addr  (bus_addr),
        .bus_siz   (bus_siz),
        .bus_rw    (bus_rw),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_din   (bus_din),
        .dsack_n   (dsack_n)
    );

    function automatic logic [7:0] sb(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input vec_t v, input int idx);
        int nb, e_rem, bi, cyc, cnt, first_ds, first_oe;
        int bad_as, bad_stab, bad_ds, bad_oe, bad_len, bad_tog, bad_wd;
        logic [23:0] e_addr, cyc_addr;
        logic [15:0] last_w;
        logic [31:0] exp_rd, got_rd;
        bit prev_as, got_done, p8;
        int n;
        logic [7:0] b0, b1;
        nb = (v.sz == 2'b00) ? 1 : (v.sz == 2'b01) ? 2 : 4;
        p8 = (v.ack == 2'b10);
        e_rem = nb; e_addr = v.addr; bi = 0; cyc = 0; cnt = 0;
        first_ds = -1; first_oe = -1; cyc_addr = '0; last_w = '0; got_rd = '0;
        bad_as = 0; bad_stab = 0; bad_ds = 0; bad_oe = 0; bad_len = 0; bad_tog = 0; bad_wd = 0;
        exp_rd = '0;
        for (int k = 0; k < nb; k++) exp_rd = (exp_rd << 8) | 32'(sb(v.addr + 24'(k)));
        @(negedge clk);
        req_write = v.wr; req_size = v.sz; req_addr = v.addr; req_wdata = v.wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        prev_as = 1'b1; got_done = 1'b0;
        for (int h = 0; h < 400 && !got_done; h++) begin
            if (!as_n && prev_as) begin
                cyc++; cnt = 0; first_ds = -1; first_oe = -1; cyc_addr = bus_addr;
                if (bus_addr != e_addr || bus_siz != 2'(e_rem) || bus_rw != !v.wr) bad_as++;
            end
            if (!as_n) begin
                cnt++;
                if (bus_addr != cyc_addr) bad_stab++;
                if (!ds_n && first_ds < 0) first_ds = cnt;
                if (bus_doe && first_oe < 0) first_oe = cnt;
                if (!ds_n) last_w = bus_dout;
                bus_din = p8 ? {sb(bus_addr), 8'hE7}
                             : {sb({bus_addr[23:1], 1'b0}), sb({bus_addr[23:1], 1'b1})};
                if (cnt >= 3 + int'(v.waits)) dsack_n = v.ack;
            end
            if (as_n && !prev_as) begin
                dsack_n = 2'b11;
                if (!ds_n) bad_tog++;
                if (cnt != 4 + int'(v.waits)) bad_len++;
                if (first_ds != (v.wr ? 3 : 1)) bad_ds++;
                if (first_oe != (v.wr ? 2 : -1)) bad_oe++;
                n = (p8 || e_rem == 1 || e_addr[0]) ? 1 : 2;
                b0 = 8'(v.wd >> (8 * (nb - 1 - bi)));
                b1 = (bi + 1 < nb) ? 8'(v.wd >> (8 * (nb - 2 - bi))) : 8'h00;
                if (v.wr) begin
                    if (p8) begin
                        if (last_w[15:8] != b0) bad_wd++;
                    end else if (n == 2) begin
                        if (last_w != {b0, b1}) bad_wd++;
                    end else if (last_w != {b0, b0}) bad_wd++;
                end
                e_addr = e_addr + 24'(n); e_rem = e_rem - n; bi = bi + n;
            end
            prev_as = as_n;
            if (xfer_done) begin
                got_done = 1'b1;
                got_rd = rd_data;
                check(req_ready, "R11", $sformatf("vec%0d ready at done", idx), req_ready, 1);
            end
            @(negedge clk);
        end
        check(got_done, "R11", $sformatf("vec%0d done pulse", idx), got_done, 1);
        check(xfer_done == 1'b0, "R11", $sformatf("vec%0d done one clock", idx), xfer_done, 0);
        check(cyc == int'(v.ncyc), p8 ? "R8" : "R7", $sformatf("vec%0d cycles (R5 ack %b)", idx, v.ack), cyc, v.ncyc);
        check(bad_as == 0, "R6", $sformatf("vec%0d addr/siz per cycle", idx), bad_as, 0);
        check(bad_stab == 0, "R2", $sformatf("vec%0d addr stable", idx), bad_stab, 0);
        check(bad_ds == 0, v.wr ? "R4" : "R3", $sformatf("vec%0d ds timing", idx), bad_ds, 0);
        check(bad_oe == 0, "R4", $sformatf("vec%0d drive timing", idx), bad_oe, 0);
        check(bad_tog == 0, "R4", $sformatf("vec%0d strobes rise together", idx), bad_tog, 0);
        check(bad_len == 0, "R12", $sformatf("vec%0d strobe length", idx), bad_len, 0);
        if (v.wr)
            check(bad_wd == 0, "R9", $sformatf("vec%0d write lanes", idx), bad_wd, 0);
        else
            check(got_rd == exp_rd, "R10", $sformatf("vec%0d read data", idx), got_rd, exp_rd);
    endtask

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(as_n && ds_n && !bus_doe && req_ready, "R1", "reset state",
              {as_n, ds_n, bus_doe, req_ready}, 4'b1101);
        rst_n = 1'b1;
        @(negedge clk);
        check(as_n && ds_n && !bus_doe && req_ready, "R1", "idle after reset",
              {as_n, ds_n, bus_doe, req_ready}, 4'b1101);

        for (int i = 0; i < NVEC; i++) run_xfer(VECS[i], i);

        // R12: strobes still low deep into a long wait with no acknowledge
        @(negedge clk);
        req_write = 1'b1; req_size = 2'b01; req_addr = 24'h00D000; req_wdata = 32'h1234;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        check(!as_n && !ds_n, "R12", "strobes held while unacknowledged",
              {as_n, ds_n}, 2'b00);
        // R1: reset in the middle of the cycle releases the bus
        rst_n = 1'b0;
        @(negedge clk);
        check(as_n && ds_n && !bus_doe && req_ready, "R1", "reset mid-cycle",
              {as_n, ds_n, bus_doe, req_ready}, 4'b1101);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(as_n && req_ready, "R1", "idle after mid-cycle reset",
              {as_n, req_ready}, 2'b11);

        // R7: a fresh transfer works after the reset
        run_xfer('{1'b0, 2'b01, 24'h00E000, 32'h0, 2'b01, 8'd0, 3'd1}, 99);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule